// File: doc/BRIEF.md
# Programmable Product-Term Plane

This block is the AND-OR plane of one logic block of a programmable-logic fabric. It takes 36 routed input signals and makes a true and an inverted copy of each, forming a 72-column literal field. Eighty-seven product terms are each built as the AND of any chosen subset of those columns. The first eighty are general terms. They are steered into the sum-of-products outputs of 16 macrocells, and a term may be shared by cells of the same group of four. The last seven are control terms: four output enables, an asynchronous set, an asynchronous reset and a clock term. Each control term has its own programmable inversion. A per-cell select picks, for each cell, one of the two output-enable terms that serve its half of the block.

The whole configuration is a single vector of `CFG_LEN` bits. It enters one bit per accepted transfer on a valid/ready serial port. It replaces the working configuration only when `cfg_load` is pulsed. The data path from `pin_in` to every output is combinational. Only the configuration is held in registers. Two flags check the loaded configuration: one for enables that leave a term's group, and one for cells given more terms than allowed.

Top module: `pterm_plane`

## Requirements
- R1: Column 2i of the literal field is `pin_in[i]`, and column 2i+1 is its inverse. Configuration bit t*72+c, when set, puts column c into product term t. A term is the AND of its selected columns.
- R2: A product term with no column selected counts as unused. It adds nothing to any sum, and its control output stays 0 whatever its inversion bit.
- R3: Bit 6264+t*16+m steers general term t (0..79) to cell m. `sum_out[m]` is the OR of the terms steered to it. One term may drive several cells of its group. A cell with no steered term gives 0.
- R4: General term t belongs to group t/20, which serves cells 4*(t/20) to 4*(t/20)+3. An enable toward a cell outside that group is ignored, and `err_group` is raised while it is loaded.
- R5: `err_count` is raised while any cell has more than 16 in-group terms enabled. Exactly 16 terms does not raise it.
- R6: Terms 80..83 drive `oe_term[0..3]`, term 84 drives `pt_set`, term 85 drives `pt_reset` and term 86 drives `pt_clk`. Bit 7544+k (k = 0..6 in that same order) inverts control output k when set.
- R7: Cells 8..15 take `oe_term[0]` when their select bit 7551+m is 0, or `oe_term[1]` when it is 1. Cells 0..7 take `oe_term[2]` or `oe_term[3]` the same way. The result appears on `cell_oe[m]`.
- R8: A bit is taken when `cfg_valid` and `cfg_ready` are both high at a clock edge. The first bit taken of the last `CFG_LEN` becomes configuration bit 0. `cfg_ready` is low in any cycle where `cfg_load` is high, so a bit offered then waits.
- R9: Shifting never changes the outputs. The shifted vector takes effect only after the clock edge at which `cfg_load` is high.
- R10: While `rst_n` is low, the working configuration is cleared. All outputs and both flags are then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Serial configuration bit offered |
| cfg_ready | output | 1 | Serial port can take a bit |
| cfg_bit | input | 1 | Serial configuration data, LSB first |
| cfg_load | input | 1 | Commit the shifted vector to the working configuration |
| pin_in | input | 36 | Routed input signals |
| sum_out | output | 16 | Per-cell sum of steered terms |
| oe_term | output | 4 | Output-enable terms after inversion |
| cell_oe | output | 16 | Per-cell chosen output enable |
| pt_set | output | 1 | Asynchronous set term after inversion |
| pt_reset | output | 1 | Asynchronous reset term after inversion |
| pt_clk | output | 1 | Clock term after inversion |
| err_group | output | 1 | An enable crosses a group boundary |
| err_count | output | 1 | A cell has more than 16 terms |

## Verification
The bench loads a configuration that places a term out of its group, tied to an input the in-group terms ignore. A plane that failed to mask the enable would light that cell's sum. Empty terms are steered to a cell and given inverted polarity. A design that let an empty AND evaluate to 1 would drive that sum or control output high. The term-count flag is probed at exactly 16 and at 17 steered terms, which catches an off-by-one in the comparison. Outputs are sampled midway through a shift and again just before the load pulse. A design that let staged bits leak into the working configuration would change its sums early.

// File: rtl/pterm_pkg.sv
package pterm_pkg;
  // Order of the control terms after the general terms; also the order
  // of their inversion bits in the configuration vector.
  typedef enum logic [2:0] {
    CT_OE0 = 3'd0,
    CT_OE1 = 3'd1,
    CT_OE2 = 3'd2,
    CT_OE3 = 3'd3,
    CT_SET = 3'd4,
    CT_RST = 3'd5,
    CT_CLK = 3'd6
  } ctl_slot_e;

  localparam int unsigned N_CTL = 7;
  localparam int unsigned N_OE  = 4;
endpackage

// File: rtl/pterm_cfg_chain.sv
// Serial staging register and working configuration.
module pterm_cfg_chain #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_valid,
  output logic         bit_ready,
  input  logic         bit_in,
  input  logic         load,
  output logic [W-1:0] active
);
  logic [W-1:0] stage;

  // A commit and a shift never share a cycle.
  assign bit_ready = ~load;

  // Newest bit enters at the top; the first bit ends up at index 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '0;
    end else if (bit_valid && bit_ready) begin
      stage <= {bit_in, stage[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= '0;
    end else if (load) begin
      active <= stage;
    end
  end
endmodule

// File: rtl/pterm_and_plane.sv
// Literal field and programmable AND of every product term.
module pterm_and_plane #(
  parameter int unsigned N_IN = 36,
  parameter int unsigned N_PT = 87,
  localparam int unsigned COLS = 2 * N_IN
) (
  input  logic [N_IN-1:0]      pin,
  input  logic [N_PT*COLS-1:0] and_cfg,
  output logic [N_PT-1:0]      pt_and,
  output logic [N_PT-1:0]      pt_used
);
  logic [COLS-1:0] lit;

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lit[2*i]   = pin[i];
    assign lit[2*i+1] = ~pin[i];
  end

  for (genvar t = 0; t < N_PT; t++) begin : g_term
    logic [COLS-1:0] sel;
    assign sel        = and_cfg[t*COLS +: COLS];
    assign pt_used[t] = |sel;
    assign pt_and[t]  = &(lit | ~sel);
  end
endmodule

// File: rtl/pterm_or_alloc.sv
// Steering and sharing of general terms into the cell sums, with checks.
module pterm_or_alloc #(
  parameter int unsigned N_GEN     = 80,
  parameter int unsigned N_CELL    = 16,
  parameter int unsigned GRP       = 4,
  parameter int unsigned MAX_STEER = 16
) (
  input  logic [N_GEN-1:0]        gen_live,
  input  logic [N_GEN*N_CELL-1:0] steer,
  output logic [N_CELL-1:0]       sum_o,
  output logic                    grp_bad,
  output logic                    cnt_bad
);
  localparam int unsigned N_GRP = N_CELL / GRP;
  localparam int unsigned TPG   = N_GEN / N_GRP;

  int cnt;

  always_comb begin
    sum_o   = '0;
    grp_bad = 1'b0;
    cnt_bad = 1'b0;
    cnt     = 0;
    for (int m = 0; m < N_CELL; m++) begin
      cnt = 0;
      for (int t = 0; t < N_GEN; t++) begin
        if (steer[t*N_CELL+m]) begin
          if ((t / TPG) == (m / GRP)) begin
            sum_o[m] = sum_o[m] | gen_live[t];
            cnt      = cnt + 1;
          end else begin
            grp_bad = 1'b1;
          end
        end
      end
      if (cnt > MAX_STEER) cnt_bad = 1'b1;
    end
  end
endmodule

// File: rtl/pterm_ctrl.sv
// Inversion of the control terms and per-cell output-enable choice.
module pterm_ctrl
  import pterm_pkg::*;
#(
  parameter int unsigned N_CELL = 16
) (
  input  logic [N_CTL-1:0]  ctl_and,
  input  logic [N_CTL-1:0]  ctl_used,
  input  logic [N_CTL-1:0]  ctl_pol,
  input  logic [N_CELL-1:0] oe_sel,
  output logic [N_OE-1:0]   oe_term,
  output logic [N_CELL-1:0] cell_oe,
  output logic              set_o,
  output logic              rst_o,
  output logic              clk_o
);
  logic [N_CTL-1:0] ctl_out;

  assign ctl_out = ctl_used & (ctl_and ^ ctl_pol);
  assign oe_term = ctl_out[N_OE-1:0];
  assign set_o   = ctl_out[CT_SET];
  assign rst_o   = ctl_out[CT_RST];
  assign clk_o   = ctl_out[CT_CLK];

  for (genvar m = 0; m < N_CELL; m++) begin : g_cell
    localparam int unsigned BASE = (m >= N_CELL / 2) ? 0 : 2;
    assign cell_oe[m] = oe_sel[m] ? oe_term[BASE+1] : oe_term[BASE];
  end
endmodule

// File: rtl/pterm_plane.sv
module pterm_plane
  import pterm_pkg::*;
#(
  parameter int unsigned N_IN      = 36,
  parameter int unsigned N_PT      = 87,
  parameter int unsigned N_GEN     = 80,
  parameter int unsigned N_CELL    = 16,
  parameter int unsigned GRP       = 4,
  parameter int unsigned MAX_STEER = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic              cfg_bit,
  input  logic              cfg_load,
  input  logic [N_IN-1:0]   pin_in,
  output logic [N_CELL-1:0] sum_out,
  output logic [3:0]        oe_term,
  output logic [N_CELL-1:0] cell_oe,
  output logic              pt_set,
  output logic              pt_reset,
  output logic              pt_clk,
  output logic              err_group,
  output logic              err_count
);
  localparam int unsigned COLS       = 2 * N_IN;
  localparam int unsigned AND_BITS   = N_PT * COLS;
  localparam int unsigned STEER_BASE = AND_BITS;
  localparam int unsigned STEER_BITS = N_GEN * N_CELL;
  localparam int unsigned POL_BASE   = STEER_BASE + STEER_BITS;
  localparam int unsigned SEL_BASE   = POL_BASE + N_CTL;
  localparam int unsigned CFG_LEN    = SEL_BASE + N_CELL;

  logic [CFG_LEN-1:0] cfg;
  logic [N_PT-1:0]    pt_and;
  logic [N_PT-1:0]    pt_used;
  logic [N_GEN-1:0]   gen_live;

  pterm_cfg_chain #(.W(CFG_LEN)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (cfg_valid),
    .bit_ready (cfg_ready),
    .bit_in    (cfg_bit),
    .load      (cfg_load),
    .active    (cfg)
  );

  pterm_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
    .pin     (pin_in),
    .and_cfg (cfg[AND_BITS-1:0]),
    .pt_and  (pt_and),
    .pt_used (pt_used)
  );

  // Unused general terms are forced off before the OR plane.
  assign gen_live = pt_and[N_GEN-1:0] & pt_used[N_GEN-1:0];

  pterm_or_alloc #(
    .N_GEN(N_GEN), .N_CELL(N_CELL), .GRP(GRP), .MAX_STEER(MAX_STEER)
  ) u_or (
    .gen_live (gen_live),
    .steer    (cfg[STEER_BASE +: STEER_BITS]),
    .sum_o    (sum_out),
    .grp_bad  (err_group),
    .cnt_bad  (err_count)
  );

  pterm_ctrl #(.N_CELL(N_CELL)) u_ctl (
    .ctl_and  (pt_and[N_PT-1:N_GEN]),
    .ctl_used (pt_used[N_PT-1:N_GEN]),
    .ctl_pol  (cfg[POL_BASE +: N_CTL]),
    .oe_sel   (cfg[SEL_BASE +: N_CELL]),
    .oe_term  (oe_term),
    .cell_oe  (cell_oe),
    .set_o    (pt_set),
    .rst_o    (pt_reset),
    .clk_o    (pt_clk)
  );
endmodule

// File: rtl/pterm_plane_chk.sv
module pterm_plane_chk #(
  parameter int unsigned N_IN   = 36,
  parameter int unsigned N_GEN  = 80,
  parameter int unsigned N_CELL = 16,
  parameter int unsigned GRP    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_load,
  input logic [N_IN-1:0]   pin_in,
  input logic [N_GEN-1:0]  gen_live,
  input logic [N_CELL-1:0] sum_out,
  input logic [3:0]        oe_term,
  input logic [N_CELL-1:0] cell_oe,
  input logic              pt_set,
  input logic              pt_reset,
  input logic              pt_clk,
  input logic              err_group,
  input logic              err_count
);
  localparam int unsigned N_GRP = N_CELL / GRP;
  localparam int unsigned TPG   = N_GEN / N_GRP;
  localparam int unsigned HALF  = N_CELL / 2;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (sum_out == '0 && oe_term == '0 && !pt_set && !pt_reset && !pt_clk && !err_group && !err_count)
  ) else $error("reset outputs not quiet"); // R10

  AST_SUM_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> ($stable(pin_in) -> ($stable(sum_out) && $stable(oe_term)))
  ) else $error("outputs moved without load"); // R9

  AST_FLAGS_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> ($stable(err_group) && $stable(err_count))
  ) else $error("flags moved without load"); // R9

  AST_UPPER_OE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_oe[N_CELL-1:HALF] != '0) |-> (oe_term[1:0] != 2'b00)
  ) else $error("upper cell enable without its terms"); // R7

  AST_LOWER_OE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_oe[HALF-1:0] != '0) |-> (oe_term[3:2] != 2'b00)
  ) else $error("lower cell enable without its terms"); // R7

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    AST_SUM_OWN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
      (sum_out[g*GRP +: GRP] != '0) |-> (gen_live[g*TPG +: TPG] != '0)
    ) else $error("sum driven from outside its group"); // R4
  end
endmodule

bind pterm_plane pterm_plane_chk #(
  .N_IN(N_IN), .N_GEN(N_GEN), .N_CELL(N_CELL), .GRP(GRP)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_load  (cfg_load),
  .pin_in    (pin_in),
  .gen_live  (gen_live),
  .sum_out   (sum_out),
  .oe_term   (oe_term),
  .cell_oe   (cell_oe),
  .pt_set    (pt_set),
  .pt_reset  (pt_reset),
  .pt_clk    (pt_clk),
  .err_group (err_group),
  .err_count (err_count)
);

// File: tb/pterm_plane_bench.sv
module pterm_plane_bench;
  localparam int COLS       = 72;
  localparam int STEER_BASE = 87 * COLS;
  localparam int POL_BASE   = STEER_BASE + 80 * 16;
  localparam int SEL_BASE   = POL_BASE + 7;
  localparam int CFG_LEN    = SEL_BASE + 16;

  // {pin_in, sum_out, oe_term, pt_set, pt_reset, pt_clk} under config A
  localparam logic [58:0] VEC [0:7] = '{
    {36'h0,          16'h0002, 4'b0010, 1'b1, 1'b0, 1'b0},
    {36'h7,          16'h0003, 4'b0010, 1'b1, 1'b0, 1'b0},
    {36'hC,          16'h0010, 4'b0010, 1'b1, 1'b0, 1'b0},
    {36'h38,         16'h0002, 4'b0010, 1'b1, 1'b0, 1'b0},
    {36'h8_0000_00C0,16'h8002, 4'b0001, 1'b1, 1'b0, 1'b0},
    {36'h1F04,       16'h0000, 4'b0110, 1'b0, 1'b1, 1'b1},
    {36'h203,        16'h0003, 4'b0010, 1'b1, 1'b0, 1'b0},
    {36'hF_FFFF_FFFF,16'h8003, 4'b0101, 1'b0, 1'b1, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        cfg_valid = 1'b0;
  logic        cfg_bit = 1'b0;
  logic        cfg_load = 1'b0;
  logic [35:0] pin_in = '0;
  logic        cfg_ready;
  logic [15:0] sum_out;
  logic [3:0]  oe_term;
  logic [15:0] cell_oe;
  logic        pt_set, pt_reset, pt_clk, err_group, err_count;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [CFG_LEN-1:0] cfg_a, cfg_b16, cfg_b17;

  always #2 clk = ~clk; // 4 ns period

  pterm_plane u_pterm_plane (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_bit(cfg_bit), .cfg_load(cfg_load), .pin_in(pin_in),
    .sum_out(sum_out), .oe_term(oe_term), .cell_oe(cell_oe),
    .pt_set(pt_set), .pt_reset(pt_reset), .pt_clk(pt_clk),
    .err_group(err_group), .err_count(err_count)
  );

  function automatic int and_at(int t, int c);
    return t * COLS + c;
  endfunction

  function automatic int steer_at(int t, int m);
    return STEER_BASE + t * 16 + m;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [CFG_LEN-1:0] v, input int lo, input int hi);
    for (int i = lo; i < hi; i++) begin
      @(negedge clk);
      cfg_valid = 1'b1;
      cfg_bit   = v[i];
    end
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic commit();
    @(negedge clk);
    cfg_load = 1'b1;
    #1;
    chk("R8 ready low during load", 64'(cfg_ready), 64'd0);
    @(negedge clk);
    cfg_load = 1'b0;
    #1;
  endtask

  // Expected per-cell enable from expected OE terms (R7 rule, config A selects)
  function automatic logic [15:0] exp_cell_oe(input logic [3:0] oe);
    logic [15:0] r;
    for (int m = 0; m < 16; m++) begin
      if (m >= 8) r[m] = (m == 8) ? oe[1] : oe[0];
      else        r[m] = (m == 0) ? oe[3] : oe[2];
    end
    return r;
  endfunction

  task automatic build_cfgs();
    cfg_a = '0;
    cfg_a[and_at(0, 0)] = 1'b1;  cfg_a[and_at(0, 2)] = 1'b1;  // in0 & in1
    cfg_a[and_at(1, 5)] = 1'b1;                               // ~in2
    cfg_a[and_at(20, 6)] = 1'b1; cfg_a[and_at(20, 9)] = 1'b1; // in3 & ~in4
    cfg_a[and_at(60, 70)] = 1'b1;                             // in35
    cfg_a[and_at(21, 10)] = 1'b1;                             // in5
    cfg_a[and_at(80, 12)] = 1'b1;
    cfg_a[and_at(81, 14)] = 1'b1;
    cfg_a[and_at(82, 16)] = 1'b1;
    cfg_a[and_at(84, 18)] = 1'b1; cfg_a[and_at(84, 20)] = 1'b1;
    cfg_a[and_at(85, 22)] = 1'b1;
    cfg_a[and_at(86, 24)] = 1'b1;
    cfg_a[steer_at(0, 0)] = 1'b1; cfg_a[steer_at(0, 1)] = 1'b1;
    cfg_a[steer_at(1, 1)] = 1'b1;
    cfg_a[steer_at(20, 4)] = 1'b1;
    cfg_a[steer_at(60, 15)] = 1'b1;
    cfg_a[steer_at(21, 0)] = 1'b1;  // out of group
    cfg_a[steer_at(2, 2)] = 1'b1;   // empty term
    cfg_a[POL_BASE + 1] = 1'b1;
    cfg_a[POL_BASE + 4] = 1'b1;
    cfg_a[SEL_BASE + 8] = 1'b1;
    cfg_a[SEL_BASE + 0] = 1'b1;

    cfg_b16 = '0;
    cfg_b16[and_at(20, 6)] = 1'b1;
    for (int t = 20; t < 36; t++) cfg_b16[steer_at(t, 5)] = 1'b1;
    for (int k = 0; k < 7; k++) cfg_b16[POL_BASE + k] = 1'b1;
    cfg_b17 = cfg_b16;
    cfg_b17[steer_at(36, 5)] = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    build_cfgs();
    #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    pin_in = '1;
    #1;
    // R10: reset state
    chk("R10 sum after reset", 64'(sum_out), 64'd0);
    chk("R10 oe after reset", 64'(oe_term), 64'd0);
    chk("R10 ctl after reset", 64'({pt_set, pt_reset, pt_clk}), 64'd0);
    chk("R10 flags after reset", 64'({err_group, err_count}), 64'd0);
    chk("R8 ready idle", 64'(cfg_ready), 64'd1);

    shift_bits(cfg_a, 0, CFG_LEN);
    commit();

    // R1 R2 R3 R4 R6 R7 table under config A
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      pin_in = VEC[v][58:23];
      #1;
      chk("R1 R3 R4 sum", 64'(sum_out), 64'(VEC[v][22:7]));
      chk("R2 R6 oe terms", 64'(oe_term), 64'(VEC[v][6:3]));
      chk("R6 set/reset/clk", 64'({pt_set, pt_reset, pt_clk}), 64'(VEC[v][2:0]));
      chk("R7 cell oe", 64'(cell_oe), 64'(exp_cell_oe(VEC[v][6:3])));
    end
    chk("R4 group flag", 64'(err_group), 64'd1);
    chk("R5 count flag A", 64'(err_count), 64'd0);

    // R9: staged bits do not leak into the outputs
    @(negedge clk);
    pin_in = 36'h7;
    shift_bits(cfg_b16, 0, CFG_LEN / 2);
    #1;
    chk("R9 mid-shift sum", 64'(sum_out), 64'h0003);
    shift_bits(cfg_b16, CFG_LEN / 2, CFG_LEN);
    #1;
    chk("R9 pre-load sum", 64'(sum_out), 64'h0003);
    chk("R9 pre-load flag", 64'(err_group), 64'd1);
    commit();

    // Config B16: 16 terms on cell 5, all control terms empty but inverted
    chk("R5 exactly 16", 64'(err_count), 64'd0);
    chk("R4 clean groups", 64'(err_group), 64'd0);
    @(negedge clk);
    pin_in = 36'h8;
    #1;
    chk("R3 sum cell5 on", 64'(sum_out), 64'h0020);
    chk("R2 empty ctl inverted", 64'({oe_term, pt_set, pt_reset, pt_clk}), 64'd0);
    @(negedge clk);
    pin_in = 36'hF_FFFF_FFF7;
    #1;
    chk("R2 empty terms add nothing", 64'(sum_out), 64'h0000);

    shift_bits(cfg_b17, 0, CFG_LEN);
    commit();
    chk("R5 seventeen terms", 64'(err_count), 64'd1);
    @(negedge clk);
    pin_in = '1;
    #1;
    chk("R3 sum cell5 17", 64'(sum_out), 64'h0020);

    // R10: reset in operation clears everything
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R10 sum in reset", 64'(sum_out), 64'd0);
    chk("R10 flags in reset", 64'({err_group, err_count}), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R10 sum after reset", 64'(sum_out), 64'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule